// File: doc/BRIEF.md
# Banked Register File with Exchangeable Working Set

This block holds the sixteen 16-bit general registers of a small 16-bit RISC core. Index 0 is a constant zero. The eight argument and temporary registers, indices 4 to 11, exist twice: a primary copy and an alternate copy. A one-cycle exchange strobe flips which copy both read ports and the write port use. This lets an interrupt handler take a fresh working set without saving anything. The remaining registers are always shared: the link, stack and global pointers (1 to 3) and the callee-saved registers (12 to 15).

The block has two combinational read ports and one write port that updates on the rising clock edge. A write and an exchange may arrive in the same cycle; the write then lands in the copy that was selected before the flip. The current selection is brought out for debug. The block does not decode instructions, sequence interrupts or forward in-flight results.

Top module: `shadow_regfile`

## Requirements
- R1: After reset, bank_sel is 0 and every register index reads 0x0000 on both read ports.
- R2: Index 0 always reads 0x0000; a write to index 0 has no effect on any register.
- R3: A write with wr_en high updates its register at the rising edge. Read ports are combinational, so a read of that index before the edge shows the old value and a read after it shows the new one.
- R4: While bank_sel is 1, reads and writes of indices 4 to 11 use the alternate copies, and the primary copies keep their contents.
- R5: A cycle with xchg high inverts bank_sel at the rising edge. Two exchanges restore the original selection. No exchange changes the contents of either copy.
- R6: Indices 1, 2, 3 and 12 to 15 have one copy, which reads and writes the same way under either value of bank_sel.
- R7: When wr_en and xchg are high in the same cycle, the write goes to the copy selected by bank_sel before that edge.
- R8: The two read ports are independent and may read any two indices, including the same one, in the same cycle.
- R9: bank_sel is 0 when the primary copies of 4 to 11 are in use and 1 when the alternate copies are in use. It changes only on a cycle with xchg high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rs1_addr | input | 4 | Read port A index |
| rs1_data | output | 16 | Read port A data (combinational) |
| rs2_addr | input | 4 | Read port B index |
| rs2_data | output | 16 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 4 | Write index |
| wr_data | input | 16 | Write data |
| xchg | input | 1 | Exchange strobe for indices 4 to 11 |
| bank_sel | output | 1 | Current copy of indices 4 to 11 (0 primary, 1 alternate) |

## Verification
Read data is due in the same cycle as its address, since there is no register on the read path. A write and an exchange each become visible one rising edge after the cycle that presents them. The bench drives all inputs on the falling edge and lets the next rising edge commit them. It then samples one nanosecond after that edge, when the write or the new bank_sel is already due. For the read-before-write case of R3, it samples in the half cycle before the edge that commits the write.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    typedef enum logic {
        BANK_PRI = 1'b0,
        BANK_ALT = 1'b1
    } bank_e;
endpackage

// File: rtl/rf_bank_ctrl.sv
module rf_bank_ctrl
    import regbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  xchg,
    output bank_e bank_q
);
    bank_e bank_d;

    always_comb begin
        bank_d = bank_q;
        if (xchg) begin
            bank_d = (bank_q == BANK_PRI) ? BANK_ALT : BANK_PRI;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= BANK_PRI;
        else        bank_q <= bank_d;
    end

    a_r5_flip_on_xchg: assert property (@(posedge clk) disable iff (!rst_n)
        xchg |=> (bank_q != $past(bank_q)));

    a_r9_hold_without_xchg: assert property (@(posedge clk) disable iff (!rst_n)
        !xchg |=> $stable(bank_q));
endmodule

// File: rtl/rf_store.sv
module rf_store
    import regbank_pkg::*;
#(
    parameter int NREG    = 16,
    parameter int XLEN    = 16,
    parameter int BANK_LO = 4,
    parameter int BANK_HI = 11,
    localparam int AW      = $clog2(NREG),
    localparam int NBANKED = BANK_HI - BANK_LO + 1,
    localparam int BW      = $clog2(NBANKED)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  bank_e                          bank,
    input  logic                           we,
    input  logic [AW-1:0]                  waddr,
    input  logic [XLEN-1:0]                wdata,
    output logic [NREG-1:0][XLEN-1:0]      prim_q,
    output logic [NBANKED-1:0][XLEN-1:0]   alt_q
);
    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0]    prim;
        logic [NBANKED-1:0][XLEN-1:0] alt;
    } store_t;

    store_t st_d, st_q;

    function automatic logic in_bank(input logic [AW-1:0] a);
        return (a >= AW'(BANK_LO)) && (a <= AW'(BANK_HI));
    endfunction

    function automatic logic [BW-1:0] alt_idx(input logic [AW-1:0] a);
        return BW'(a - AW'(BANK_LO));
    endfunction

    always_comb begin
        st_d = st_q;
        if (we && (waddr != '0)) begin
            if ((bank == BANK_ALT) && in_bank(waddr)) begin
                st_d.alt[alt_idx(waddr)] = wdata;
            end else begin
                st_d.prim[waddr] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prim_q = st_q.prim;
    assign alt_q  = st_q.alt;

    a_r2_zero_slot_clear: assert property (@(posedge clk) disable iff (!rst_n)
        prim_q[0] == '0);

    for (genvar i = 1; i < NREG; i++) begin : g_chk
        if (i >= BANK_LO && i <= BANK_HI) begin : g_banked
            a_r4_alt_write_spares_primary: assert property (@(posedge clk) disable iff (!rst_n)
                (we && bank == BANK_ALT && waddr == AW'(i)) |=> $stable(prim_q[i]));
            a_r4_pri_write_spares_alt: assert property (@(posedge clk) disable iff (!rst_n)
                (we && bank == BANK_PRI && waddr == AW'(i)) |=> $stable(alt_q[i-BANK_LO]));
        end else begin : g_shared
            a_r6_shared_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
                !(we && waddr == AW'(i)) |=> $stable(prim_q[i]));
        end
    end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import regbank_pkg::*;
#(
    parameter int NREG    = 16,
    parameter int XLEN    = 16,
    parameter int BANK_LO = 4,
    parameter int BANK_HI = 11,
    localparam int AW      = $clog2(NREG),
    localparam int NBANKED = BANK_HI - BANK_LO + 1,
    localparam int BW      = $clog2(NBANKED)
) (
    input  logic [AW-1:0]                  addr,
    input  bank_e                          bank,
    input  logic [NREG-1:0][XLEN-1:0]      prim,
    input  logic [NBANKED-1:0][XLEN-1:0]   alt,
    output logic [XLEN-1:0]                data
);
    logic banked;

    assign banked = (addr >= AW'(BANK_LO)) && (addr <= AW'(BANK_HI));

    always_comb begin
        if (addr == '0) begin
            data = '0;
        end else if (banked && (bank == BANK_ALT)) begin
            data = alt[BW'(addr - AW'(BANK_LO))];
        end else begin
            data = prim[addr];
        end
    end
endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
    import regbank_pkg::*;
#(
    parameter int NREG    = 16,
    parameter int XLEN    = 16,
    parameter int BANK_LO = 4,
    parameter int BANK_HI = 11,
    localparam int AW      = $clog2(NREG),
    localparam int NBANKED = BANK_HI - BANK_LO + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   rs1_addr,
    output logic [XLEN-1:0] rs1_data,
    input  logic [AW-1:0]   rs2_addr,
    output logic [XLEN-1:0] rs2_data,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [XLEN-1:0] wr_data,
    input  logic            xchg,
    output logic            bank_sel
);
    bank_e                          bank_q;
    logic [NREG-1:0][XLEN-1:0]      prim_q;
    logic [NBANKED-1:0][XLEN-1:0]   alt_q;
    logic [1:0][AW-1:0]             rd_addr;
    logic [1:0][XLEN-1:0]           rd_data;

    rf_bank_ctrl u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .xchg   (xchg),
        .bank_q (bank_q)
    );

    rf_store #(
        .NREG(NREG), .XLEN(XLEN), .BANK_LO(BANK_LO), .BANK_HI(BANK_HI)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .bank   (bank_q),
        .we     (wr_en),
        .waddr  (wr_addr),
        .wdata  (wr_data),
        .prim_q (prim_q),
        .alt_q  (alt_q)
    );

    assign rd_addr[0] = rs1_addr;
    assign rd_addr[1] = rs2_addr;

    for (genvar p = 0; p < 2; p++) begin : g_rport
        rf_read_port #(
            .NREG(NREG), .XLEN(XLEN), .BANK_LO(BANK_LO), .BANK_HI(BANK_HI)
        ) u_rp (
            .addr (rd_addr[p]),
            .bank (bank_q),
            .prim (prim_q),
            .alt  (alt_q),
            .data (rd_data[p])
        );
    end

    assign rs1_data = rd_data[0];
    assign rs2_data = rd_data[1];
    assign bank_sel = (bank_q == BANK_ALT);

    a_r7_write_uses_prior_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && xchg && wr_addr == AW'(BANK_LO) && !bank_sel) |=>
            (alt_q[0] == $past(alt_q[0])));
endmodule

// File: tb/sim_shadow_regfile.sv
module sim_shadow_regfile;
    localparam time HALF = 2ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rs1_addr = '0, rs2_addr = '0, wr_addr = '0;
    logic [15:0] rs1_data, rs2_data, wr_data = '0;
    logic        wr_en = 1'b0, xchg = 1'b0;
    logic        bank_sel;

    int n_chk = 0;
    int n_bad = 0;

    always #HALF clk = ~clk;

    shadow_regfile u0 (
        .clk(clk), .rst_n(rst_n),
        .rs1_addr(rs1_addr), .rs1_data(rs1_data),
        .rs2_addr(rs2_addr), .rs2_data(rs2_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .xchg(xchg), .bank_sel(bank_sel)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: drive on falling edge, commit on rising edge, settle 1 ns
    task automatic step(input logic we, input logic [3:0] a, input logic [15:0] d, input logic x);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; xchg = x;
        @(posedge clk);
        #1ns;
        wr_en = 1'b0; xchg = 1'b0;
    endtask

    task automatic rd1(input string req, input logic [3:0] a, input logic [15:0] exp);
        rs1_addr = a;
        #100ps;
        chk(req, rs1_data, exp);
    endtask

    task automatic t_reset();
        chk("R1 bank_sel", {15'd0, bank_sel}, 16'd0);
        for (int i = 0; i < 16; i++) begin
            rs1_addr = 4'(i); rs2_addr = 4'(15 - i);
            #100ps;
            chk("R1 port A", rs1_data, 16'h0000);
            chk("R1 port B", rs2_data, 16'h0000);
        end
    endtask

    task automatic t_zero();
        step(1'b1, 4'd0, 16'hFFFF, 1'b0);
        rd1("R2 r0 read", 4'd0, 16'h0000);
        rd1("R2 r1 untouched", 4'd1, 16'h0000);
    endtask

    task automatic t_write_timing();
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd1; wr_data = 16'h1111;
        rd1("R3 before edge", 4'd1, 16'h0000);
        @(posedge clk);
        #1ns;
        wr_en = 1'b0;
        rd1("R3 after edge", 4'd1, 16'h1111);
        step(1'b1, 4'd15, 16'hF00F, 1'b0);
        step(1'b1, 4'd7, 16'h7777, 1'b0);
        step(1'b1, 4'd4, 16'h4444, 1'b0);
        step(1'b1, 4'd11, 16'hBBBB, 1'b0);
        rs1_addr = 4'd15; rs2_addr = 4'd7;
        #100ps;
        chk("R8 port A r15", rs1_data, 16'hF00F);
        chk("R8 port B r7", rs2_data, 16'h7777);
        rs2_addr = 4'd15;
        #100ps;
        chk("R8 same index", rs2_data, 16'hF00F);
    endtask

    task automatic t_bank();
        step(1'b0, 4'd0, 16'h0, 1'b1);
        chk("R9 bank_sel alt", {15'd0, bank_sel}, 16'd1);
        rd1("R4 alt r7 empty", 4'd7, 16'h0000);
        rd1("R4 alt r4 empty", 4'd4, 16'h0000);
        rd1("R4 alt r11 empty", 4'd11, 16'h0000);
        step(1'b1, 4'd7, 16'hABCD, 1'b0);
        rd1("R4 alt r7 written", 4'd7, 16'hABCD);
        rd1("R6 r1 in alt", 4'd1, 16'h1111);
        rd1("R6 r15 in alt", 4'd15, 16'hF00F);
        step(1'b1, 4'd12, 16'h5555, 1'b0);
        step(1'b1, 4'd3, 16'h3333, 1'b0);
        step(1'b0, 4'd0, 16'h0, 1'b0);
        chk("R9 no xchg hold", {15'd0, bank_sel}, 16'd1);
        step(1'b0, 4'd0, 16'h0, 1'b1);
        chk("R5 back to primary", {15'd0, bank_sel}, 16'd0);
        rd1("R4 primary r7 kept", 4'd7, 16'h7777);
        rd1("R5 primary r4 kept", 4'd4, 16'h4444);
        rd1("R5 primary r11 kept", 4'd11, 16'hBBBB);
        rd1("R6 r12 shared", 4'd12, 16'h5555);
        rd1("R6 r3 shared", 4'd3, 16'h3333);
        step(1'b0, 4'd0, 16'h0, 1'b1);
        rd1("R5 alt r7 kept", 4'd7, 16'hABCD);
    endtask

    task automatic t_same_cycle();
        // bank_sel is 1 here: write + exchange -> alternate copy of r8
        step(1'b1, 4'd8, 16'h8888, 1'b1);
        chk("R7 bank flipped", {15'd0, bank_sel}, 16'd0);
        rd1("R7 primary r8 untouched", 4'd8, 16'h0000);
        step(1'b0, 4'd0, 16'h0, 1'b1);
        rd1("R7 alt r8 got write", 4'd8, 16'h8888);
        // bank_sel is 1: write + exchange from alternate side into r4? use primary start
        step(1'b0, 4'd0, 16'h0, 1'b1);
        step(1'b1, 4'd5, 16'h5A5A, 1'b1);
        chk("R7 now alt", {15'd0, bank_sel}, 16'd1);
        rd1("R7 alt r5 untouched", 4'd5, 16'h0000);
        step(1'b0, 4'd0, 16'h0, 1'b1);
        rd1("R7 primary r5 got write", 4'd5, 16'h5A5A);
    endtask

    initial begin
        #(HALF * 2 * 100000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #100ps;
        t_reset();
        t_zero();
        t_write_timing();
        t_bank();
        t_same_cycle();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule